// File: doc/BRIEF.md
# Multi-Mode Compare and PWM Channel

This block is one compare channel of a programmable counter array. It watches a 16-bit counter that lives outside the channel and is shared with the other channels. From that count it drives one output pin, a match flag, an overflow flag and an interrupt request. A two-bit function field picks the behaviour: a software timer that only raises the flag, a toggle output that flips the pin on a full 16-bit match, a frequency output that flips the pin on a low-byte match and then moves its own low byte forward by the high byte, or pulse-width modulation. In PWM, a separate wide-mode bit chooses between 16-bit PWM and a narrow PWM whose resolution of 8, 9, 10 or 11 bits comes from a shared cycle-length field.

The counter is an input. A strobe tells the channel that the count has taken a new value, and comparisons are made only on strobed cycles. A single write port loads either the compare register or the buffered reload register. The reload register can only be reached in 9, 10 and 11-bit PWM with the select bit set, and the same steering applies to the read port. In narrow PWM the compare value is refreshed at every wrap of the low field, so a new duty never cuts into a period that is already running. If the comparator is disabled, the toggle outputs hold their level and every PWM mode drives the pin low.

Top module: `pca_compare_channel`

## Requirements
- R1: While reset is low at a clock edge, the pin, match flag, overflow flag, interrupt request, compare register and reload register all become 0.
- R2: Function 00 (timer): a strobed count equal to all 16 compare bits, with the comparator on, sets the match flag one cycle later and leaves the pin unchanged.
- R3: Function 01 (toggle): a strobed 16-bit match with the comparator on inverts the pin and sets the match flag one cycle later.
- R4: Function 10 (frequency): a strobed match of the low 8 count bits against the compare low byte, with the comparator on, inverts the pin, sets the match flag and adds the compare high byte to the compare low byte modulo 256. The high byte is unchanged.
- R5: Function 11 with the wide bit clear is n-bit PWM, where n = 8 + cycle-length (00→8, 01→9, 10→10, 11→11). A strobe whose low n count bits are all zero drives the pin high. A strobe whose low n bits equal the low n compare bits drives it low, and low wins when both happen. Over 2^n consecutive counts the pin is high for exactly C samples, where C is the n-bit compare value.
- R6: At each n-bit wrap in n-bit PWM, the compare register takes the reload register (9 to 11 bits) or takes the compare high byte into its low byte (8 bits).
- R7: Writes and reads reach the reload register only when the mode is n-bit PWM, the cycle-length is not 00 and the select bit is 1. In every other case they reach the compare register.
- R8: Function 11 with the wide bit set is 16-bit PWM. A strobed count of 0 drives the pin high and a strobed 16-bit match drives it low, so a compare of C gives C high samples per period.
- R9: With the comparator off, the toggle and frequency functions neither invert the pin nor set the flag, and any PWM mode drives the pin to 0 by the next cycle.
- R10: In PWM modes a match sets the match flag only when the flag-enable input is 1.
- R11: The overflow flag is set one cycle after an n-bit wrap in n-bit PWM, whatever the comparator state, and never in 16-bit PWM.
- R12: The interrupt request is (match flag AND match-interrupt enable) OR (overflow flag AND overflow-interrupt enable), with no added delay.
- R13: The flag-clear inputs clear their flags on the next edge. A set in the same cycle takes priority over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt | input | 16 | Shared counter value |
| cnt_step | input | 1 | The counter holds a new value this cycle |
| fsel | input | 2 | Function: 00 timer, 01 toggle, 10 frequency, 11 PWM |
| pwm_wide | input | 1 | In PWM, 1 selects 16-bit PWM |
| cyc_len | input | 2 | Shared narrow-PWM resolution code |
| cmp_en | input | 1 | Comparator enable |
| flag_en | input | 1 | Match flag enable in PWM modes |
| irq_en | input | 1 | Match interrupt enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| reload_sel | input | 1 | Steers register access to the reload register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| flag_clr | input | 1 | Clear match flag |
| ovf_clr | input | 1 | Clear overflow flag |
| rd_data | output | 16 | Contents of the steered register |
| pin_out | output | 1 | Channel output pin |
| match_flag | output | 1 | Match flag |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The pin, the two flags and the compare register change on the clock edge that samples a strobed count. The bench therefore drives each count at a falling edge and reads the results at the next falling edge, one register stage later. The interrupt request and the read data are combinational from register state and inputs, so the bench reads them a short delay after changing an enable or the select bit, with no clock edge in between. PWM duty is measured by counting high samples across one full period of the low n bits, which holds only if every wrap and match lands on the same cycle as its strobe.

// File: rtl/pcc_pkg.sv
// Shared types for the compare channel.
// Assumes: the function field is two bits wide.
package pcc_pkg;
    typedef enum logic [1:0] {
        FN_TIMER  = 2'b00,
        FN_TOGGLE = 2'b01,
        FN_FREQ   = 2'b10,
        FN_PWM    = 2'b11
    } func_e;
endpackage

// File: rtl/pcc_event.sv
// Event detector: finds comparator hits and PWM field wraps for a strobed count.
// Assumes: BASE_RES + max cycle-length <= CNT_W and BASE_RES == CNT_W/2.
module pcc_event
    import pcc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BASE_RES = 8,
    parameter int CYC_W    = 2
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CYC_W-1:0] cyc_len,
    input  func_e            fn,
    input  logic             wide,
    input  logic             cmp_en,
    input  logic             cnt_step,
    output logic             hit,
    output logic             wrap
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] res_mask;
    logic             eq_full, eq_half, eq_res, zero_res, zero_full, raw_eq;

    // Build the mask covering the active narrow-PWM bits.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            res_mask[i] = (i < (BASE_RES + int'(cyc_len)));
        end
    end

    // Compare the count against the compare value at each width.
    always_comb begin
        eq_full   = (cnt == cmp);
        eq_half   = (cnt[HALF_W-1:0] == cmp[HALF_W-1:0]);
        eq_res    = (((cnt ^ cmp) & res_mask) == '0);
        zero_res  = ((cnt & res_mask) == '0);
        zero_full = (cnt == '0);
    end

    // Pick the comparison that applies to the current function.
    always_comb begin
        case (fn)
            FN_FREQ: raw_eq = eq_half;
            FN_PWM:  raw_eq = wide ? eq_full : eq_res;
            default: raw_eq = eq_full;
        endcase
        hit  = cnt_step && cmp_en && raw_eq;
        wrap = cnt_step && (fn == FN_PWM) && (wide ? zero_full : zero_res);
    end
endmodule

// File: rtl/pcc_regs.sv
// Compare and reload storage with write steering and hardware updates.
// Assumes: a software write has priority over reload copy and frequency advance.
module pcc_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             to_reload,
    input  logic             reload_now,
    input  logic             reload_reg,
    input  logic             freq_adv,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] rld_q
);
    localparam int HALF_W = CNT_W / 2;

    // Reload register: loaded by steered writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rld_q <= '0;
        else if (wr_en && to_reload) rld_q <= wr_data;
    end

    // Compare register: write, then wrap reload, then frequency advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_en && !to_reload) begin
            cmp_q <= wr_data;
        end else if (reload_now) begin
            if (reload_reg) cmp_q <= rld_q;
            else            cmp_q[HALF_W-1:0] <= cmp_q[CNT_W-1:HALF_W];
        end else if (freq_adv) begin
            cmp_q[HALF_W-1:0] <= cmp_q[HALF_W-1:0] + cmp_q[CNT_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/pcc_wave.sv
// Output stage: pin waveform, match and overflow flags, interrupt request.
// Assumes: hit and wrap are already qualified by the counter strobe.
module pcc_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic wrap,
    input  logic is_pwm,
    input  logic is_pwmn,
    input  logic is_toggle,
    input  logic cmp_en,
    input  logic flag_en,
    input  logic flag_clr,
    input  logic ovf_clr,
    input  logic irq_en,
    input  logic ovf_irq_en,
    output logic pin_out,
    output logic match_flag,
    output logic ovf_flag,
    output logic irq
);
    // Pin: PWM forced low when off, match low beats wrap high; toggle modes invert.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pin_out <= 1'b0;
        else if (is_pwm && !cmp_en)   pin_out <= 1'b0;
        else if (is_pwm && hit)       pin_out <= 1'b0;
        else if (is_pwm && wrap)      pin_out <= 1'b1;
        else if (is_toggle && hit)    pin_out <= ~pin_out;
    end

    // Match flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               match_flag <= 1'b0;
        else if (hit && (!is_pwm || flag_en))     match_flag <= 1'b1;
        else if (flag_clr)                        match_flag <= 1'b0;
    end

    // Overflow flag: narrow PWM wraps only.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_flag <= 1'b0;
        else if (wrap && is_pwmn)  ovf_flag <= 1'b1;
        else if (ovf_clr)          ovf_flag <= 1'b0;
    end

    // Interrupt request from enabled flags.
    always_comb irq = (match_flag && irq_en) || (ovf_flag && ovf_irq_en);
endmodule

// File: rtl/pca_compare_channel.sv
// Top of one compare channel: decodes the mode, steers register access,
// and joins the event detector, register store and output stage.
// Assumes: the counter and its strobe come from shared logic outside.
module pca_compare_channel
    import pcc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BASE_RES = 8,
    parameter int CYC_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_step,
    input  logic [1:0]       fsel,
    input  logic             pwm_wide,
    input  logic [CYC_W-1:0] cyc_len,
    input  logic             cmp_en,
    input  logic             flag_en,
    input  logic             irq_en,
    input  logic             ovf_irq_en,
    input  logic             reload_sel,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pin_out,
    output logic             match_flag,
    output logic             ovf_flag,
    output logic             irq
);
    func_e            fn;
    logic             is_pwm, is_pwmn, is_toggle, to_reload, reload_reg;
    logic             hit, wrap;
    logic [CNT_W-1:0] cmp_q, rld_q;

    // Mode decode and access steering.
    always_comb begin
        fn         = func_e'(fsel);
        is_pwm     = (fn == FN_PWM);
        is_pwmn    = is_pwm && !pwm_wide;
        is_toggle  = (fn == FN_TOGGLE) || (fn == FN_FREQ);
        reload_reg = (cyc_len != '0);
        to_reload  = is_pwmn && reload_reg && reload_sel;
        rd_data    = to_reload ? rld_q : cmp_q;
    end

    pcc_event #(.CNT_W(CNT_W), .BASE_RES(BASE_RES), .CYC_W(CYC_W)) u_event (
        .cnt(cnt), .cmp(cmp_q), .cyc_len(cyc_len), .fn(fn), .wide(pwm_wide),
        .cmp_en(cmp_en), .cnt_step(cnt_step), .hit(hit), .wrap(wrap)
    );

    pcc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .to_reload(to_reload), .reload_now(wrap && is_pwmn),
        .reload_reg(reload_reg), .freq_adv(hit && (fn == FN_FREQ)),
        .cmp_q(cmp_q), .rld_q(rld_q)
    );

    pcc_wave u_wave (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wrap(wrap), .is_pwm(is_pwm),
        .is_pwmn(is_pwmn), .is_toggle(is_toggle), .cmp_en(cmp_en),
        .flag_en(flag_en), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .irq_en(irq_en), .ovf_irq_en(ovf_irq_en), .pin_out(pin_out),
        .match_flag(match_flag), .ovf_flag(ovf_flag), .irq(irq)
    );
endmodule

// File: rtl/pcc_checker.sv
// Property checker for the compare channel, bound to the top module.
// Assumes: it sees the top's ports and its compare register.
module pcc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_step,
    input logic [1:0]       fsel,
    input logic             pwm_wide,
    input logic             cmp_en,
    input logic             wr_en,
    input logic [CNT_W-1:0] cmp_q,
    input logic             pin_out,
    input logic             match_flag,
    input logic             ovf_flag
);
    localparam int HALF_W = CNT_W / 2;

    assert_timer_pin_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b00) |=> (pin_out == $past(pin_out)));

    assert_flag_needs_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(cnt_step));

    assert_toggle_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b01 && cmp_en && cnt_step && cnt == cmp_q)
        |=> (pin_out != $past(pin_out)) && match_flag);

    assert_freq_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b10 && cmp_en && cnt_step && !wr_en &&
         cnt[HALF_W-1:0] == cmp_q[HALF_W-1:0])
        |=> cmp_q[HALF_W-1:0] == ($past(cmp_q[HALF_W-1:0]) + $past(cmp_q[CNT_W-1:HALF_W])));

    assert_pwm_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b11 && !cmp_en) |=> !pin_out);

    assert_ovf_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(cnt_step && fsel == 2'b11 && !pwm_wide));
endmodule

bind pca_compare_channel pcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_step(cnt_step), .fsel(fsel),
    .pwm_wide(pwm_wide), .cmp_en(cmp_en), .wr_en(wr_en), .cmp_q(cmp_q),
    .pin_out(pin_out), .match_flag(match_flag), .ovf_flag(ovf_flag)
);

// File: tb/tb_pca_compare_channel.sv
module tb_pca_compare_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_step = 1'b0;
    logic [1:0]  fsel = '0;
    logic        pwm_wide = 1'b0;
    logic [1:0]  cyc_len = '0;
    logic        cmp_en = 1'b0, flag_en = 1'b0, irq_en = 1'b0, ovf_irq_en = 1'b0;
    logic        reload_sel = 1'b0, wr_en = 1'b0, flag_clr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pin_out, match_flag, ovf_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pca_compare_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_step(cnt_step), .fsel(fsel),
        .pwm_wide(pwm_wide), .cyc_len(cyc_len), .cmp_en(cmp_en), .flag_en(flag_en),
        .irq_en(irq_en), .ovf_irq_en(ovf_irq_en), .reload_sel(reload_sel),
        .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .pin_out(pin_out), .match_flag(match_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  cyc;
        logic [15:0] cval;
        logic        cen;
        logic [15:0] highs;
    } vec_t;

    // Narrow PWM duty vectors (R5, R9): high samples per 2^n counts.
    localparam vec_t VECS [0:7] = '{
        '{2'd0, 16'd64,   1'b1, 16'd64},
        '{2'd0, 16'd0,    1'b1, 16'd0},
        '{2'd0, 16'd255,  1'b1, 16'd255},
        '{2'd1, 16'd300,  1'b1, 16'd300},
        '{2'd2, 16'd1000, 1'b1, 16'd1000},
        '{2'd3, 16'd1,    1'b1, 16'd1},
        '{2'd3, 16'd2047, 1'b1, 16'd2047},
        '{2'd1, 16'd200,  1'b0, 16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] v);
        cnt = v;
        cnt_step = 1'b1;
        @(negedge clk);
        cnt_step = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_flags();
        flag_clr = 1'b1;
        ovf_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        ovf_clr = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pin", 32'(pin_out), 0);
        chk("R1 flag", 32'(match_flag), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rd", 32'(rd_data), 0);

        // R3 toggle output
        fsel = 2'b01; cmp_en = 1'b1; irq_en = 1'b1;
        wr(16'h1234);
        step(16'h1233);
        chk("R3 no match pin", 32'(pin_out), 0);
        chk("R3 no match flag", 32'(match_flag), 0);
        step(16'h1234);
        chk("R3 toggle pin", 32'(pin_out), 1);
        chk("R3 flag", 32'(match_flag), 1);
        chk("R12 irq on flag", 32'(irq), 1);
        step(16'h1235);
        chk("R3 hold pin", 32'(pin_out), 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R13 flag cleared", 32'(match_flag), 0);
        chk("R12 irq drops", 32'(irq), 0);

        // R2 timer: flag only, pin held high
        fsel = 2'b00;
        wr(16'h0040);
        step(16'h0040);
        chk("R2 flag", 32'(match_flag), 1);
        chk("R2 pin unchanged", 32'(pin_out), 1);
        clr_flags();

        // R3 toggle back
        fsel = 2'b01;
        step(16'h0040);
        chk("R3 toggle low", 32'(pin_out), 0);
        clr_flags();

        // R9 comparator off in toggle mode
        cmp_en = 1'b0;
        step(16'h0040);
        chk("R9 no toggle", 32'(pin_out), 0);
        chk("R9 no flag", 32'(match_flag), 0);

        // R13 set beats clear
        cmp_en = 1'b1; flag_clr = 1'b1;
        step(16'h0040);
        flag_clr = 1'b0;
        chk("R13 set wins", 32'(match_flag), 1);
        chk("R3 pin after toggle", 32'(pin_out), 1);
        clr_flags();

        // R4 frequency output
        fsel = 2'b10;
        wr(16'h0503);
        step(16'h0002);
        chk("R4 no match", 32'(pin_out), 1);
        step(16'h0103);
        chk("R4 toggle", 32'(pin_out), 0);
        chk("R4 advance", 32'(rd_data), 32'h0508);
        step(16'h0208);
        chk("R4 second toggle", 32'(pin_out), 1);
        chk("R4 second advance", 32'(rd_data), 32'h050D);
        wr(16'h80FF);
        step(16'h00FF);
        chk("R4 modulo wrap", 32'(rd_data), 32'h807F);
        clr_flags();

        // R7 steering
        fsel = 2'b11; pwm_wide = 1'b0; cyc_len = 2'd1; reload_sel = 1'b0;
        wr(16'h0011);
        reload_sel = 1'b1;
        wr(16'h0022);
        #1 chk("R7 reload read", 32'(rd_data), 32'h0022);
        reload_sel = 1'b0;
        #1 chk("R7 compare read", 32'(rd_data), 32'h0011);
        cyc_len = 2'd0; reload_sel = 1'b1;
        #1 chk("R7 8-bit ignores select", 32'(rd_data), 32'h0011);
        cyc_len = 2'd1; reload_sel = 1'b0;
        @(negedge clk);

        // R6 reload at wrap
        step(16'h0005);
        chk("R6 no early reload", 32'(rd_data), 32'h0011);
        step(16'h0200);
        chk("R6 9-bit reload", 32'(rd_data), 32'h0022);
        chk("R5 wrap pin high", 32'(pin_out), 1);
        cyc_len = 2'd0;
        wr(16'h4710);
        step(16'h0300);
        chk("R6 8-bit high into low", 32'(rd_data), 32'h4747);

        // R10 flag enable in PWM
        step(16'h0347);
        chk("R5 match pin low", 32'(pin_out), 0);
        chk("R10 flag gated", 32'(match_flag), 0);
        flag_en = 1'b1;
        step(16'h0447);
        chk("R10 flag set", 32'(match_flag), 1);

        // R11 overflow, R12 irq
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk("R13 ovf cleared", 32'(ovf_flag), 0);
        step(16'h0500);
        chk("R11 ovf set", 32'(ovf_flag), 1);
        irq_en = 1'b0; ovf_irq_en = 1'b0;
        #1 chk("R12 irq masked", 32'(irq), 0);
        ovf_irq_en = 1'b1;
        #1 chk("R12 ovf irq", 32'(irq), 1);
        ovf_irq_en = 1'b0; flag_en = 1'b0;
        @(negedge clk);
        clr_flags();

        // R8 16-bit PWM
        pwm_wide = 1'b1; cyc_len = 2'd2; reload_sel = 1'b1;
        wr(16'h0005);
        reload_sel = 1'b0;
        #1 chk("R7 wide writes compare", 32'(rd_data), 32'h0005);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            step(16'(k));
            chk("R8 pwm16 pin", 32'(pin_out), (k < 5) ? 1 : 0);
        end
        chk("R11 no ovf wide", 32'(ovf_flag), 0);

        // R9 PWM forced low
        step(16'h0000);
        chk("R8 wrap high", 32'(pin_out), 1);
        cmp_en = 1'b0;
        @(negedge clk);
        chk("R9 pwm off low", 32'(pin_out), 0);

        // R5 table walk
        pwm_wide = 1'b0; flag_en = 1'b0;
        foreach (VECS[i]) begin
            int highs;
            highs = 0;
            cyc_len = VECS[i].cyc;
            cmp_en = VECS[i].cen;
            reload_sel = 1'b0;
            if (VECS[i].cyc == 2'd0) begin
                wr({VECS[i].cval[7:0], VECS[i].cval[7:0]});
            end else begin
                wr(VECS[i].cval);
                reload_sel = 1'b1;
                wr(VECS[i].cval);
                reload_sel = 1'b0;
            end
            clr_flags();
            for (int k = 0; k < (1 << (8 + int'(VECS[i].cyc))); k++) begin
                step(16'(k));
                if (pin_out) highs++;
            end
            chk(VECS[i].cen ? "R5 duty" : "R9 duty off", 32'(highs), 32'(VECS[i].highs));
            chk("R11 ovf per period", 32'(ovf_flag), 1);
        end

        summary();
    end
endmodule